// File: doc/BRIEF.md
# Peripheral Kernel-Clock Source Select Register

This block is a single 32-bit control register on a simple memory-mapped slave port. It holds the kernel-clock source choice for three serial ports, three I2C ports and four timers, and drives those choices out as registered select codes. Downstream glitch-free clock multiplexers consume the codes. The clock sources and the multiplexers are outside this block.

Software writes the register with byte-lane strobes, so a byte, half-word or word store changes only the lanes it covers. Writes finish with no wait states. A read request returns the register image, with every reserved bit as zero, on the cycle after the request.

The four timer select bits follow a live clock-tree condition. They accept a write only while the condition holds. The condition holds when the system clock runs from the PLL and both the AHB and APB2 prescaler codes mean divide-by-1. When the condition goes away, hardware forces the timer bits to zero, and software must set them again later.

Top module: `clksel_reg`

## Requirements
- R1: After synchronous reset every select output is zero and a read of the register returns 0x0000_0000.
- R2: Only an access with address 0x30 reaches the register. A write to any other address changes nothing, and a read of any other address returns zero.
- R3: Each write strobe bit enables one byte lane: strobe bit k covers data bits 8k+7..8k. Lanes whose strobe is low keep their contents.
- R4: Serial-port selects are 2-bit read/write fields: port 0 at bits 1:0, port 1 at bits 17:16, port 2 at bits 19:18. The codes are 00 peripheral bus clock, 01 system clock, 10 low-speed external oscillator, 11 high-speed internal oscillator. Each output equals its field.
- R5: The I2C selects are read/write bits 6:4 and appear on `iic_sel` in the same order (bit 4 maps to `iic_sel[0]`).
- R6: Bits 31:20, 15:14, 12, 9, 7 and 3:2 are reserved. They always read 0, and writes to them are ignored.
- R7: Timer select bits 8, 10, 11 and 13 drive `tmr_sel[0]`, `[1]`, `[2]` and `[3]`, where 0 means the peripheral bus clock and 1 means the PLL VCO. A write reaches them only while the qualifying condition holds: `sys_src` = 2'b10 (PLL), `ahb_div` = 0 and `apb2_div` = 0.
- R8: In any cycle where the condition is false, the timer bits become 0 at the next clock edge. They stay 0 when the condition returns, until software writes them again.
- R9: A write that arrives in the same cycle the condition goes false does not set the timer bits, because the hardware clear wins.
- R10: A read request makes `rd_valid` high on the next cycle with the register image on `rd_data`. A write request does not raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_be | input | 4 | Byte-lane write strobes |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| sys_src | input | 2 | Current system clock source code (2'b10 = PLL) |
| ahb_div | input | 4 | AHB prescaler code (0 = divide-by-1) |
| apb2_div | input | 3 | APB2 prescaler code (0 = divide-by-1) |
| ser_sel0 | output | 2 | Serial port 0 source code |
| ser_sel1 | output | 2 | Serial port 1 source code |
| ser_sel2 | output | 2 | Serial port 2 source code |
| iic_sel | output | 3 | I2C port source bits |
| tmr_sel | output | 4 | Timer source bits |

## Verification
A wrong internal state shows up on the select outputs on the edge after the write or status change that caused it. A read of the register shows the same error one cycle after the read request. A timer bit that is not cleared, or that is set while the condition is false, shows on `tmr_sel` one cycle after the status inputs change. The bench sweeps every combination of the status inputs and every strobe pattern. It compares both the outputs and the read data with a model computed from the bit masks.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int DW = 32;
  localparam int NLANE = DW / 8;
  localparam logic [DW-1:0] PLAIN_MASK = 32'h000F_0073;
  localparam logic [DW-1:0] TMR_MASK   = 32'h0000_2D00;
  localparam logic [DW-1:0] RSVD_MASK  = ~(PLAIN_MASK | TMR_MASK);
  localparam int NSER = 3;
  localparam int SER_W = 2;
  localparam int IIC_W = 3;
  localparam int IIC_LSB = 4;
  localparam int NTMR = 4;
endpackage

// File: rtl/clksel_qualify.sv
module clksel_qualify #(
  parameter int SRC_W = 2,
  parameter int AHB_W = 4,
  parameter int APB_W = 3,
  parameter logic [SRC_W-1:0] SRC_PLL = 2'b10
) (
  input  logic [SRC_W-1:0] sys_src,
  input  logic [AHB_W-1:0] ahb_div,
  input  logic [APB_W-1:0] apb2_div,
  output logic             qual
);
  always_comb begin
    qual = (sys_src == SRC_PLL) && (ahb_div == '0) && (apb2_div == '0);
  end
endmodule

// File: rtl/clksel_field.sv
module clksel_field #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wen,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      nxt[i] = wen[i] ? d[i] : q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wen == '0) |=> $stable(q)); // R3
endmodule

// File: rtl/clksel_gated.sv
module clksel_gated #(
  parameter int DW = 32,
  parameter logic [DW-1:0] MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          qual,
  input  logic [DW-1:0] wen,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  logic [DW-1:0] nxt;

  always_comb begin
    for (int b = 0; b < DW; b++) begin
      if (!MASK[b])     nxt[b] = 1'b0;
      else if (!qual)   nxt[b] = 1'b0;
      else if (wen[b])  nxt[b] = d[b];
      else              nxt[b] = q[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !qual |=> (q == '0)); // R8
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (qual && ((wen & MASK) == '0)) |=> (q == $past(q))); // R7
endmodule

// File: rtl/clksel_reg.sv
module clksel_reg
  import clksel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h30,
  parameter int SRC_W = 2,
  parameter int AHB_W = 4,
  parameter int APB_W = 3,
  parameter logic [SRC_W-1:0] SRC_PLL = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NLANE-1:0]  req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic [SRC_W-1:0]  sys_src,
  input  logic [AHB_W-1:0]  ahb_div,
  input  logic [APB_W-1:0]  apb2_div,
  output logic [SER_W-1:0]  ser_sel0,
  output logic [SER_W-1:0]  ser_sel1,
  output logic [SER_W-1:0]  ser_sel2,
  output logic [IIC_W-1:0]  iic_sel,
  output logic [NTMR-1:0]   tmr_sel
);
  localparam int SER_LSB [NSER] = '{0, 16, 18};

  logic          hit;
  logic          wr_hit;
  logic          rd_req;
  logic          rd_hit;
  logic [DW-1:0] bit_wen;
  logic          qual;
  logic [SER_W-1:0] ser_q [NSER];
  logic [IIC_W-1:0] iic_q;
  logic [DW-1:0] tmr_q;
  logic [DW-1:0] image;

  always_comb begin
    hit    = req_valid && (req_addr == REG_OFFSET);
    wr_hit = hit && req_write;
    rd_req = req_valid && !req_write;
    rd_hit = hit && !req_write;
    for (int b = 0; b < DW; b++) begin
      bit_wen[b] = wr_hit && req_be[b/8];
    end
  end

  clksel_qualify #(
    .SRC_W(SRC_W), .AHB_W(AHB_W), .APB_W(APB_W), .SRC_PLL(SRC_PLL)
  ) u_qualify (
    .sys_src(sys_src), .ahb_div(ahb_div), .apb2_div(apb2_div), .qual(qual)
  );

  for (genvar g = 0; g < NSER; g++) begin : g_ser
    clksel_field #(.W(SER_W)) u_ser (
      .clk(clk), .rst(rst),
      .wen(bit_wen[SER_LSB[g] +: SER_W]),
      .d(req_wdata[SER_LSB[g] +: SER_W]),
      .q(ser_q[g])
    );
  end

  clksel_field #(.W(IIC_W)) u_iic (
    .clk(clk), .rst(rst),
    .wen(bit_wen[IIC_LSB +: IIC_W]),
    .d(req_wdata[IIC_LSB +: IIC_W]),
    .q(iic_q)
  );

  clksel_gated #(.DW(DW), .MASK(TMR_MASK)) u_tmr (
    .clk(clk), .rst(rst), .qual(qual),
    .wen(bit_wen), .d(req_wdata), .q(tmr_q)
  );

  always_comb begin
    image = tmr_q;
    for (int g = 0; g < NSER; g++) begin
      image[SER_LSB[g] +: SER_W] = ser_q[g];
    end
    image[IIC_LSB +: IIC_W] = iic_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_hit ? image : '0;
    end
  end

  always_comb begin
    ser_sel0 = ser_q[0];
    ser_sel1 = ser_q[1];
    ser_sel2 = ser_q[2];
    iic_sel  = iic_q;
    tmr_sel  = {tmr_q[13], tmr_q[11], tmr_q[10], tmr_q[8]};
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R10
  AST_WR_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rd_valid); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ((rd_data & RSVD_MASK) == '0)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (req_addr != REG_OFFSET)) |=> (rd_data == '0)); // R2
endmodule

// File: tb/clksel_reg_bench.sv
module clksel_reg_bench;
  localparam logic [31:0] PLAIN = 32'h000F_0073;
  localparam logic [31:0] TMR   = 32'h0000_2D00;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = 8'h0;
  logic [3:0]  req_be = 4'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [1:0]  sys_src = 2'b10;
  logic [3:0]  ahb_div = 4'h0;
  logic [2:0]  apb2_div = 3'h0;
  logic [1:0]  ser_sel0, ser_sel1, ser_sel2;
  logic [2:0]  iic_sel;
  logic [3:0]  tmr_sel;

  int tests = 0;
  int fails = 0;
  logic [31:0] exp_reg = 32'h0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clksel_reg u_clksel_reg (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sys_src(sys_src),
    .ahb_div(ahb_div), .apb2_div(apb2_div), .ser_sel0(ser_sel0),
    .ser_sel1(ser_sel1), .ser_sel2(ser_sel2), .iic_sel(iic_sel),
    .tmr_sel(tmr_sel)
  );

  function automatic bit qual_f(logic [1:0] s, logic [3:0] a, logic [2:0] p);
    return (s == 2'b10) && (a == 4'h0) && (p == 3'h0);
  endfunction

  function automatic logic [31:0] lanes(logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic logic [3:0] tmr_of(logic [31:0] r);
    return {r[13], r[11], r[10], r[8]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    logic v;
    rd(8'h30, d, v);
    check(req, d, exp_reg);
    check(req, {31'b0, v}, 32'h1);
    check(req, {30'b0, ser_sel0}, {30'b0, exp_reg[1:0]});
    check(req, {30'b0, ser_sel1}, {30'b0, exp_reg[17:16]});
    check(req, {30'b0, ser_sel2}, {30'b0, exp_reg[19:18]});
    check(req, {29'b0, iic_sel}, {29'b0, exp_reg[6:4]});
    check(req, {28'b0, tmr_sel}, {28'b0, tmr_of(exp_reg)});
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all("R1");

    // R3 R4 R5 R6 R7: every strobe pattern, qualifying condition true
    for (int be = 0; be < 16; be++) begin
      logic [31:0] pat;
      pat = (be[0] ? 32'hFFFF_FFFF : 32'hA5C3_5A3C) ^ (32'h0101_0101 * be);
      wr(8'h30, be[3:0], pat);
      exp_reg = (exp_reg & ~lanes(be[3:0])) | (pat & lanes(be[3:0]) & (PLAIN | TMR));
      check_all("R3_R4_R5_R6_R7");
    end

    // R4 each serial code value on every port
    for (int c = 0; c < 4; c++) begin
      logic [31:0] pat;
      pat = {12'h0, c[1:0], c[1:0], 14'h0, c[1:0]};
      wr(8'h30, 4'b0101, pat);
      exp_reg = (exp_reg & ~lanes(4'b0101)) | (pat & lanes(4'b0101) & (PLAIN | TMR));
      check_all("R4");
    end

    // R2 other addresses
    wr(8'h34, 4'hF, 32'hFFFF_FFFF);
    check_all("R2");
    rd(8'h2C, d, v);
    check("R2", d, 32'h0);

    // R10 write does not raise rd_valid
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h30; req_be = 4'h0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10", {31'b0, rd_valid}, 32'h0);

    // R7 R8 sweep over all status combinations
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 16; a++)
        for (int p = 0; p < 8; p++) begin
          bit q;
          q = qual_f(s[1:0], a[3:0], p[2:0]);
          @(negedge clk);
          sys_src = 2'b10; ahb_div = 4'h0; apb2_div = 3'h0;
          wr(8'h30, 4'b0010, 32'hFFFF_FFFF);
          @(negedge clk);
          sys_src = s[1:0]; ahb_div = a[3:0]; apb2_div = p[2:0];
          @(negedge clk);
          check("R8", {28'b0, tmr_sel}, q ? 32'hF : 32'h0);
          wr(8'h30, 4'b0010, 32'h0);
          wr(8'h30, 4'b0010, 32'hFFFF_FFFF);
          check("R7", {28'b0, tmr_sel}, q ? 32'hF : 32'h0);
        end

    // R8 no return to 1 when the condition comes back
    @(negedge clk);
    sys_src = 2'b10; ahb_div = 4'h0; apb2_div = 3'h0;
    wr(8'h30, 4'b0010, 32'hFFFF_FFFF);
    exp_reg = (exp_reg & ~lanes(4'b0010)) | (32'hFFFF_FFFF & lanes(4'b0010) & (PLAIN | TMR));
    @(negedge clk); apb2_div = 3'h1;
    @(negedge clk); apb2_div = 3'h0;
    exp_reg = exp_reg & ~TMR;
    repeat (2) @(negedge clk);
    check_all("R8");

    // R9 write in the same cycle the condition drops
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h30; req_be = 4'b0010;
    req_wdata = 32'hFFFF_FFFF; ahb_div = 4'h8;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'h0;
    check("R9", {28'b0, tmr_sel}, 32'h0);
    ahb_div = 4'h0;
    @(negedge clk);
    check_all("R9");

    // R7 hold under condition when lane 1 strobe is off
    wr(8'h30, 4'b0010, 32'h0000_2D00);
    exp_reg = exp_reg | TMR;
    wr(8'h30, 4'b1101, 32'h0);
    exp_reg = exp_reg & ~(lanes(4'b1101) & PLAIN);
    check_all("R7");

    // R1 reset again clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_reg = 32'h0;
    check_all("R1");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule